// File: doc/BRIEF.md
# SCSI Initiator Abort Sequencer

This block forces a connected SCSI target to let go of the bus. Once started, it raises ATN and then handles whatever phase the target presents, one REQ/ACK handshake at a time, using asynchronous handshaking only. In an input phase (I/O high), it takes the byte and throws it away. In an output phase, it drives the abort message 0x06. If the target switches to message-out, ATN is dropped for that byte, because the message has been delivered. The sequence ends when the initiator connection goes away, or when the attempt budget runs out.

The budget is the 24-bit count of bytes still outstanding in the interrupted transfer plus a fixed margin. Running out of budget while still connected is reported as a failure. At the end of the sequence the block asks for a controller reset, unless a reselection is pending. If the bus was already idle, or the block was no longer the initiator when the request came, it finishes at once and touches nothing. A programmable timeout bounds each wait for REQ to fall, so a hung target cannot stall the sequence.

Top module: `scsi_abort_seq`

## Requirements
- R1: A start request sampled while `bsy_i` is low or `init_conn_i` is low finishes at once. `done_o` is high in the cycle after that edge, with ATN, ACK, `ctrl_rst_o` and `failed_o` all low.
- R2: The sequence makes at most `remain_i + MARGIN` attempts (MARGIN defaults to 1024). Each attempt is exactly one rising edge of `ack_o`.
- R3: Every attempt asserts ATN (two cycles after an accepted start, and one cycle after the previous ACK release) before waiting for REQ. If `init_conn_i` falls while the block waits, the sequence ends.
- R4: In the message-out phase (`msg_i`=1, `cd_i`=1, `io_i`=0), ATN goes low in the same cycle that ACK rises.
- R5: In an input phase (`io_i`=1), ACK rises one cycle after REQ is sampled high. The data bus is not driven, and the byte is discarded.
- R6: In an output phase (`io_i`=0), `data_o` = 0x06 with `data_oe_o` high, for as long as ACK is high.
- R7: ACK falls one cycle after REQ is sampled low.
- R8: If the budget runs out while the block is still connected, `failed_o` goes high together with `done_o`. It stays high until the next accepted start.
- R9: `ctrl_rst_o` pulses together with `done_o` on a non-early finish, unless `resel_pend_i` is high in that cycle.
- R10: If REQ stays high, ACK is released `timeout_cfg_i + 1` cycles after it rose.
- R11: `done_o` lasts a single cycle, and a start request while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Abort request |
| req_i | input | 1 | Target REQ |
| io_i | input | 1 | Target I/O (1 = input to initiator) |
| cd_i | input | 1 | Target C/D |
| msg_i | input | 1 | Target MSG |
| bsy_i | input | 1 | Bus BSY (phase active) |
| init_conn_i | input | 1 | Connected as initiator |
| data_i | input | 8 | Bus data in (discarded) |
| remain_i | input | CNT_W | Remaining transfer bytes |
| resel_pend_i | input | 1 | Reselection interrupt pending |
| timeout_cfg_i | input | TMO_W | REQ-fall timeout in cycles |
| atn_o | output | 1 | ATN |
| ack_o | output | 1 | ACK |
| data_o | output | 8 | Data byte driven |
| data_oe_o | output | 1 | Data drive enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle finish strobe |
| failed_o | output | 1 | Budget exhausted while connected |
| ctrl_rst_o | output | 1 | Controller reset pulse |

## Verification
All outputs are registered or decoded from the state, so each response is due a fixed number of edges after its cause. `done_o` is due one edge after an early start, ATN two edges after an accepted start, ACK one edge after REQ is seen high, and the ACK release one edge after REQ is seen low, or `timeout_cfg_i + 1` edges after ACK rose. The bench drives inputs on falling edges and samples one falling edge per expected register stage. Responses whose timing depends on the current state, such as the end after a disconnect, are polled with a bound. The attempt budget is swept over the remaining counts 0 to 3, and the ACK pulses are counted against `remain + 1024`.

// File: rtl/abrt_pkg.sv
package abrt_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CHECK = 3'd1,
    S_WREQ  = 3'd2,
    S_WFALL = 3'd3,
    S_END   = 3'd4
  } abrt_state_e;

  localparam logic [7:0] ABORT_MSG = 8'h06;
endpackage

// File: rtl/abrt_budget.sv
module abrt_budget #(
  parameter int CNT_W  = 24,
  parameter int MARGIN = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] remain,
  output logic             empty
);
  localparam int BW = CNT_W + 1;

  logic [BW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = BW'(remain) + BW'(MARGIN);
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign empty = (cnt_q == '0);
endmodule

// File: rtl/abrt_timer.sv
module abrt_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             hit
);
  logic [TMO_W-1:0] cnt_q, cnt_d;

  assign hit = (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)              cnt_d = '0;
    else if (run && !hit) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scsi_abort_seq.sv
module scsi_abort_seq
  import abrt_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int MARGIN = 1024,
  parameter int TMO_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             req_i,
  input  logic             io_i,
  input  logic             cd_i,
  input  logic             msg_i,
  input  logic             bsy_i,
  input  logic             init_conn_i,
  input  logic [7:0]       data_i,
  input  logic [CNT_W-1:0] remain_i,
  input  logic             resel_pend_i,
  input  logic [TMO_W-1:0] timeout_cfg_i,
  output logic             atn_o,
  output logic             ack_o,
  output logic [7:0]       data_o,
  output logic             data_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             failed_o,
  output logic             ctrl_rst_o
);
  abrt_state_e st_q, st_d;
  logic atn_q, atn_d, ack_q, ack_d, drv_q, drv_d;
  logic full_q, full_d, fail_q, fail_d;
  logic bud_load, bud_dec, bud_empty;
  logic tmr_clr, tmr_run, tmr_hit;
  logic msg_out_ph;
  logic [7:0] sink_byte;

  assign msg_out_ph = msg_i & cd_i & ~io_i;
  // Incoming bytes are taken and dropped; nothing downstream uses them.
  assign sink_byte  = data_i;

  abrt_budget #(.CNT_W(CNT_W), .MARGIN(MARGIN)) u_budget (
    .clk(clk), .rst_n(rst_n), .load(bud_load), .dec(bud_dec),
    .remain(remain_i), .empty(bud_empty)
  );

  abrt_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run),
    .limit(timeout_cfg_i), .hit(tmr_hit)
  );

  always_comb begin
    st_d     = st_q;
    atn_d    = atn_q;
    ack_d    = ack_q;
    drv_d    = drv_q;
    full_d   = full_q;
    fail_d   = fail_q;
    bud_load = 1'b0;
    bud_dec  = 1'b0;
    tmr_clr  = 1'b0;
    tmr_run  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          fail_d = 1'b0;
          if (bsy_i && init_conn_i) begin
            bud_load = 1'b1;
            full_d   = 1'b1;
            st_d     = S_CHECK;
          end else begin
            full_d = 1'b0;
            st_d   = S_END;
          end
        end
      end
      S_CHECK: begin
        if (!init_conn_i) begin
          atn_d = 1'b0;
          st_d  = S_END;
        end else if (bud_empty) begin
          atn_d  = 1'b0;
          fail_d = 1'b1;
          st_d   = S_END;
        end else begin
          bud_dec = 1'b1;
          atn_d   = 1'b1;
          st_d    = S_WREQ;
        end
      end
      S_WREQ: begin
        if (!init_conn_i) begin
          atn_d = 1'b0;
          st_d  = S_END;
        end else if (req_i) begin
          ack_d   = 1'b1;
          drv_d   = ~io_i;
          tmr_clr = 1'b1;
          if (msg_out_ph) atn_d = 1'b0;
          st_d = S_WFALL;
        end
      end
      S_WFALL: begin
        tmr_run = 1'b1;
        if (!req_i || tmr_hit) begin
          ack_d = 1'b0;
          drv_d = 1'b0;
          st_d  = S_CHECK;
        end
      end
      S_END: begin
        atn_d = 1'b0;
        st_d  = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      atn_q  <= 1'b0;
      ack_q  <= 1'b0;
      drv_q  <= 1'b0;
      full_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      atn_q  <= atn_d;
      ack_q  <= ack_d;
      drv_q  <= drv_d;
      full_q <= full_d;
      fail_q <= fail_d;
    end
  end

  assign atn_o      = atn_q;
  assign ack_o      = ack_q;
  assign data_oe_o  = drv_q;
  assign data_o     = drv_q ? ABORT_MSG : 8'h00;
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = (st_q == S_END);
  assign failed_o   = fail_q;
  assign ctrl_rst_o = (st_q == S_END) & full_q & ~resel_pend_i;
endmodule

// File: rtl/abrt_chk.sv
module abrt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic       resel_pend_i,
  input logic       atn_o,
  input logic       ack_o,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       failed_o,
  input logic       ctrl_rst_o
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!atn_o && !ack_o));

  p_ack_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_i));

  p_drive_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> (ack_o && data_o == 8'h06));

  p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst_o |-> (done_o && !resel_pend_i));

  p_fail_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failed_o) |-> done_o);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind scsi_abort_seq abrt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .resel_pend_i(resel_pend_i),
  .atn_o(atn_o), .ack_o(ack_o), .data_o(data_o), .data_oe_o(data_oe_o),
  .busy_o(busy_o), .done_o(done_o), .failed_o(failed_o),
  .ctrl_rst_o(ctrl_rst_o)
);

// File: tb/tb_scsi_abort_seq.sv
module tb_scsi_abort_seq;
  localparam int CNT_W  = 24;
  localparam int MARGIN = 1024;
  localparam int TMO_W  = 8;

  logic clk, rst_n, start_i, req_i, io_i, cd_i, msg_i, bsy_i, init_conn_i;
  logic [7:0] data_i;
  logic [CNT_W-1:0] remain_i;
  logic resel_pend_i;
  logic [TMO_W-1:0] timeout_cfg_i;
  logic atn_o, ack_o, data_oe_o, busy_o, done_o, failed_o, ctrl_rst_o;
  logic [7:0] data_o;

  int checks = 0;
  int errors = 0;

  scsi_abort_seq #(.CNT_W(CNT_W), .MARGIN(MARGIN), .TMO_W(TMO_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_i(req_i),
    .io_i(io_i), .cd_i(cd_i), .msg_i(msg_i), .bsy_i(bsy_i),
    .init_conn_i(init_conn_i), .data_i(data_i), .remain_i(remain_i),
    .resel_pend_i(resel_pend_i), .timeout_cfg_i(timeout_cfg_i),
    .atn_o(atn_o), .ack_o(ack_o), .data_o(data_o), .data_oe_o(data_oe_o),
    .busy_o(busy_o), .done_o(done_o), .failed_o(failed_o),
    .ctrl_rst_o(ctrl_rst_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic nclk();
    @(negedge clk);
  endtask

  task automatic wait_ack(input logic lvl);
    for (int i = 0; i < 40 && ack_o !== lvl; i++) nclk();
  endtask

  task automatic wait_done();
    for (int i = 0; i < 10 && done_o !== 1'b1; i++) nclk();
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    nclk();
    start_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    logic prev_ack;
    rst_n = 1'b0; start_i = 1'b0; req_i = 1'b0; io_i = 1'b0; cd_i = 1'b0;
    msg_i = 1'b0; bsy_i = 1'b0; init_conn_i = 1'b0; data_i = 8'hA5;
    remain_i = '0; resel_pend_i = 1'b0; timeout_cfg_i = 8'd20;
    repeat (3) nclk();
    rst_n = 1'b1;
    nclk();
    chk(!atn_o && !ack_o && !done_o && !busy_o && !ctrl_rst_o && !failed_o,
        "R1 reset state", {atn_o, ack_o, done_o, busy_o, ctrl_rst_o}, 0);

    // R1 early exit: bus idle
    init_conn_i = 1'b1; bsy_i = 1'b0;
    pulse_start();
    chk(done_o === 1'b1, "R1 early done", done_o, 1);
    chk(!ctrl_rst_o && !atn_o && !ack_o && !failed_o, "R1 early quiet",
        {ctrl_rst_o, atn_o, ack_o, failed_o}, 0);
    nclk();
    chk(done_o === 1'b0, "R11 done one cycle", done_o, 0);

    // Input phase attempt
    bsy_i = 1'b1; io_i = 1'b1; cd_i = 1'b1; msg_i = 1'b1;
    pulse_start();
    nclk();
    chk(atn_o === 1'b1, "R3 ATN before REQ", atn_o, 1);
    chk(ack_o === 1'b0, "R3 no ACK before REQ", ack_o, 0);
    req_i = 1'b1;
    nclk();
    chk(ack_o === 1'b1, "R5 ACK after REQ", ack_o, 1);
    chk(data_oe_o === 1'b0, "R5 input not driven", data_oe_o, 0);
    start_i = 1'b1; bsy_i = 1'b0;          // R11 ignored while busy
    nclk();
    start_i = 1'b0; bsy_i = 1'b1;
    chk(busy_o === 1'b1 && done_o === 1'b0, "R11 start ignored while busy",
        {busy_o, done_o}, 2);
    chk(ack_o === 1'b1, "R5 ACK held while REQ high", ack_o, 1);
    req_i = 1'b0;
    nclk();
    chk(ack_o === 1'b0, "R7 ACK release after REQ low", ack_o, 0);
    nclk();
    chk(atn_o === 1'b1, "R3 ATN reasserted", atn_o, 1);

    // Output phase (data out)
    io_i = 1'b0; cd_i = 1'b0; msg_i = 1'b0;
    req_i = 1'b1;
    wait_ack(1'b1);
    chk(data_oe_o === 1'b1 && data_o === 8'h06, "R6 abort byte driven", data_o, 6);
    chk(atn_o === 1'b1, "R4 ATN kept outside message-out", atn_o, 1);
    req_i = 1'b0;
    nclk();
    chk(ack_o === 1'b0 && data_oe_o === 1'b0, "R7 release drive", {ack_o, data_oe_o}, 0);

    // Message-out phase
    io_i = 1'b0; cd_i = 1'b1; msg_i = 1'b1;
    req_i = 1'b1;
    wait_ack(1'b1);
    chk(atn_o === 1'b0, "R4 ATN dropped in message-out", atn_o, 0);
    chk(data_o === 8'h06, "R6 abort byte in message-out", data_o, 6);
    req_i = 1'b0;
    nclk();
    nclk();
    chk(atn_o === 1'b1, "R3 ATN set on next attempt", atn_o, 1);

    // R10 timeout with REQ stuck high
    timeout_cfg_i = 8'd5;
    io_i = 1'b1; cd_i = 1'b0; msg_i = 1'b0;
    req_i = 1'b1;
    wait_ack(1'b1);
    repeat (5) nclk();
    chk(ack_o === 1'b1, "R10 ACK held before timeout", ack_o, 1);
    nclk();
    chk(ack_o === 1'b0, "R10 ACK released at timeout", ack_o, 0);
    req_i = 1'b0;
    nclk();

    // Disconnect ends sequence with controller reset
    init_conn_i = 1'b0;
    wait_done();
    chk(done_o === 1'b1, "R3 disconnect ends", done_o, 1);
    chk(ctrl_rst_o === 1'b1, "R9 reset pulse at end", ctrl_rst_o, 1);
    chk(failed_o === 1'b0, "R8 no fail on disconnect", failed_o, 0);
    nclk();
    init_conn_i = 1'b1;
    timeout_cfg_i = 8'd20;

    // Reselection pending suppresses reset
    pulse_start();
    nclk();
    resel_pend_i = 1'b1;
    init_conn_i = 1'b0;
    wait_done();
    chk(done_o === 1'b1 && ctrl_rst_o === 1'b0, "R9 reset suppressed by resel",
        ctrl_rst_o, 0);
    nclk();
    resel_pend_i = 1'b0; init_conn_i = 1'b1;

    // Budget sweep
    for (int r = 0; r < 4; r++) begin
      remain_i = CNT_W'(r);
      io_i = r[0]; cd_i = 1'b0; msg_i = 1'b0;
      pulse_start();
      cnt = 0; prev_ack = 1'b0;
      for (int i = 0; i < 20000 && done_o !== 1'b1; i++) begin
        if (ack_o && !prev_ack) cnt++;
        prev_ack = ack_o;
        req_i = ack_o ? 1'b0 : atn_o;
        nclk();
      end
      req_i = 1'b0;
      chk(cnt == r + MARGIN, "R2 attempt count", cnt, r + MARGIN);
      chk(failed_o === 1'b1 && done_o === 1'b1, "R8 fail at done",
          {failed_o, done_o}, 3);
      chk(ctrl_rst_o === 1'b1, "R9 reset after exhaustion", ctrl_rst_o, 1);
      nclk();
      chk(failed_o === 1'b1, "R8 fail held", failed_o, 1);
    end

    // New start clears fail
    init_conn_i = 1'b0;
    pulse_start();
    chk(done_o === 1'b1 && failed_o === 1'b0, "R8 fail cleared on start",
        failed_o, 0);
    chk(ctrl_rst_o === 1'b0, "R1 no reset on early exit", ctrl_rst_o, 0);
    nclk();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule